// File: doc/BRIEF.md
# Tag-Driven DMA Chain Sequencer

This block sequences one DMA channel that moves quadword (16-byte) payloads between main memory and a scratchpad. In chain mode the channel fetches a 128-bit tag, takes a payload count, an address and a tag kind from it, requests the payload move, and then either fetches the next tag or finishes. In normal mode it moves the programmed count once and finishes.

Two directions are supported. In scratch-to-memory mode the tags sit inline in the scratchpad stream, ahead of each payload. In memory-to-scratch mode the tags are read through a separate tag pointer, and the tag kind decides where the payload lives and where the next tag is. In that mode the tag can also be copied into the scratchpad ahead of its payload. A tag of the stall kind can update a stall address, and a tag with its interrupt bit set can end the chain when the channel allows it.

The tag memory and the payload mover sit outside the block, each behind a request/acknowledge pair. A move is one request carrying source, destination and count, and it completes on a single acknowledge.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `irq`, `tag_req` and `mv_req` are low, and `stall_addr` is zero.
- R2: With `cfg_chain`=0, a start issues exactly one move of `cfg_count` quadwords, then completes. In scratch-to-memory mode (`cfg_dir`=0) the source is the scratch address and the destination is the memory address; `cfg_dir`=1 swaps them. A count of zero completes with no move. After a move both addresses have advanced by count×16.
- R3: Tag layout: count in bits 15:0, kind in bits 30:28, interrupt bit in bit 31, address in bits 63:32. In scratch-to-memory chain mode each tag is read at the scratch address, and that address then advances by 16. The memory address is loaded from the tag's address field, and the payload is read from the scratch address that follows the tag.
- R4: In scratch-to-memory mode, kind 7 ends the chain after its payload. Every other kind continues the chain.
- R5: In scratch-to-memory mode, a kind-0 tag with `cfg_stall_src`=1 sets `stall_addr` to the tag address + count×16. No other tag changes `stall_addr`.
- R6: When `cfg_irq_en`=1 and the tag's interrupt bit is set, the chain ends after that tag's payload. With `cfg_irq_en`=0 the bit has no effect.
- R7: In memory-to-scratch mode tags are read at the tag pointer. The kind sets the addresses, where T is the tag pointer and A is the tag address field. Kind 0: memory address A, pointer T+16, end. Kind 1: memory address T+16, pointer T+16+count×16. Kind 2: memory address T+16, pointer A. Kinds 3 and 4: memory address A, pointer T+16. Kinds 5, 6 and 7: memory address T+16, pointer unchanged, end.
- R8: In memory-to-scratch mode with `cfg_fwd_en`=1, each tag is first written as a one-quadword move with `mv_fwd`=1 and `mv_tag` equal to the tag. Its destination is the scratch address, which then advances by 16, and it comes before the payload.
- R9: A tag with count zero produces no payload move, and no move request ever carries a count of zero.
- R10: A chain-mode start with a nonzero `cfg_count` first moves that pending payload without fetching a tag. If `cfg_last_id` is 7, or is 0 in memory-to-scratch mode, the channel then completes. Otherwise tag fetching follows.
- R11: On completion `irq` is high for exactly one cycle while `busy` is still high, and `busy` is low in the next cycle.
- R12: A start while `busy` is high is ignored.
- R13: Only one of `tag_req` and `mv_req` is high at a time. Each request and its address and count fields stay stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| cfg_chain | input | 1 | 1 = chain mode, 0 = normal mode |
| cfg_dir | input | 1 | 0 = scratch to memory, 1 = memory to scratch |
| cfg_irq_en | input | 1 | Tag interrupt bit may end the chain |
| cfg_fwd_en | input | 1 | Copy tags into scratch (memory-to-scratch mode) |
| cfg_stall_src | input | 1 | Stall control taken from this channel |
| cfg_last_id | input | 3 | Kind of the tag that loaded the pending count |
| cfg_count | input | 16 | Initial quadword count |
| cfg_mem_addr | input | AW | Initial memory address |
| cfg_scr_addr | input | AW | Initial scratch address |
| cfg_tag_ptr | input | AW | Initial tag pointer |
| tag_req | output | 1 | Tag fetch request |
| tag_addr | output | AW | Tag fetch address |
| tag_ack | input | 1 | Tag fetch acknowledge, data valid |
| tag_data | input | 128 | Fetched tag quadword |
| mv_req | output | 1 | Move request |
| mv_fwd | output | 1 | Move is a tag copy |
| mv_src | output | AW | Move source address (zero for a tag copy) |
| mv_dst | output | AW | Move destination address |
| mv_count | output | 16 | Move length in quadwords |
| mv_tag | output | 128 | Tag quadword for a tag copy |
| mv_ack | input | 1 | Move complete |
| busy | output | 1 | Channel running (start bit) |
| irq | output | 1 | End-of-transfer interrupt pulse |
| stall_addr | output | AW | Stall address register |
| ch_mem_addr | output | AW | Current memory address |
| ch_scr_addr | output | AW | Current scratch address |
| ch_tag_ptr | output | AW | Current tag pointer |
| ch_count | output | 16 | Current quadword count |

## Verification
A single kind-0 tag can do two things in the same acknowledge cycle: write the stall address and end the chain because its interrupt bit is set. The bench sends such a tag with the stall source and the interrupt enable both on, and places a valid tag after it. It then expects `stall_addr` to hold the tag address plus the payload span, exactly one payload move, one tag fetch and one interrupt. A second run sets the interrupt bit in memory-to-scratch mode with the enable off, and expects the chain to continue through the later tags.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int TAG_W = 128;
    localparam int CNT_W = 16;
    localparam int QW_SH = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWD,
        ST_MOVE,
        ST_CHECK,
        ST_DONE
    } seq_state_e;

    // tag kinds
    localparam logic [2:0] KIND_STALL_OR_REFEND = 3'd0;
    localparam logic [2:0] KIND_CONT            = 3'd1;
    localparam logic [2:0] KIND_NEXT            = 3'd2;
    localparam logic [2:0] KIND_REF             = 3'd3;
    localparam logic [2:0] KIND_REF_STALL       = 3'd4;
    localparam logic [2:0] KIND_STOP            = 3'd7;

    // does a resumed payload with this last kind finish the channel
    function automatic logic resume_ends(input logic dir, input logic [2:0] kind);
        return (kind == KIND_STOP) || (dir && kind == KIND_STALL_OR_REFEND);
    endfunction

endpackage

// File: rtl/dcs_tag_decode.sv
module dcs_tag_decode
    import dcs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             dir,
    input  logic [AW-1:0]    tptr,
    input  logic [CNT_W-1:0] f_cnt,
    input  logic [2:0]       f_kind,
    input  logic [31:0]      f_addr,
    output logic [AW-1:0]    next_mem,
    output logic [AW-1:0]    next_tptr,
    output logic [AW-1:0]    span,
    output logic             ends,
    output logic             stall_hit
);
    localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SH;

    logic [AW-1:0] addr_f;
    logic [AW-1:0] after_tag;

    assign addr_f    = AW'(f_addr);
    assign span      = AW'(f_cnt) << QW_SH;
    assign after_tag = tptr + QW_BYTES;

    always_comb begin
        next_mem  = addr_f;
        next_tptr = tptr;
        ends      = 1'b0;
        stall_hit = 1'b0;
        if (!dir) begin
            // inline tags: pointer unused, address from tag
            ends      = (f_kind == KIND_STOP);
            stall_hit = (f_kind == KIND_STALL_OR_REFEND);
        end else begin
            unique case (f_kind)
                KIND_STALL_OR_REFEND: begin
                    next_mem  = addr_f;
                    next_tptr = after_tag;
                    ends      = 1'b1;
                end
                KIND_CONT: begin
                    next_mem  = after_tag;
                    next_tptr = after_tag + span;
                end
                KIND_NEXT: begin
                    next_mem  = after_tag;
                    next_tptr = addr_f;
                end
                KIND_REF, KIND_REF_STALL: begin
                    next_mem  = addr_f;
                    next_tptr = after_tag;
                end
                default: begin
                    next_mem  = after_tag;
                    next_tptr = tptr;
                    ends      = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/dcs_mover.sv
module dcs_mover
    import dcs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             fwd,
    input  logic             dir,
    input  logic [AW-1:0]    mem,
    input  logic [AW-1:0]    scr,
    input  logic [CNT_W-1:0] cnt,
    output logic [AW-1:0]    src,
    output logic [AW-1:0]    dst,
    output logic [CNT_W-1:0] mv_cnt,
    output logic [AW-1:0]    mem_after,
    output logic [AW-1:0]    scr_after
);
    localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SH;

    logic [AW-1:0] span;
    assign span = AW'(cnt) << QW_SH;

    always_comb begin
        if (fwd) begin
            src       = '0;
            dst       = scr;
            mv_cnt    = CNT_W'(1);
            mem_after = mem;
            scr_after = scr + QW_BYTES;
        end else begin
            src       = dir ? mem : scr;
            dst       = dir ? scr : mem;
            mv_cnt    = cnt;
            mem_after = mem + span;
            scr_after = scr + span;
        end
    end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dcs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_chain,
    input  logic              cfg_dir,
    input  logic              cfg_irq_en,
    input  logic              cfg_fwd_en,
    input  logic              cfg_stall_src,
    input  logic [2:0]        cfg_last_id,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [AW-1:0]     cfg_mem_addr,
    input  logic [AW-1:0]     cfg_scr_addr,
    input  logic [AW-1:0]     cfg_tag_ptr,
    output logic              tag_req,
    output logic [AW-1:0]     tag_addr,
    input  logic              tag_ack,
    input  logic [TAG_W-1:0]  tag_data,
    output logic              mv_req,
    output logic              mv_fwd,
    output logic [AW-1:0]     mv_src,
    output logic [AW-1:0]     mv_dst,
    output logic [CNT_W-1:0]  mv_count,
    output logic [TAG_W-1:0]  mv_tag,
    input  logic              mv_ack,
    output logic              busy,
    output logic              irq,
    output logic [AW-1:0]     stall_addr,
    output logic [AW-1:0]     ch_mem_addr,
    output logic [AW-1:0]     ch_scr_addr,
    output logic [AW-1:0]     ch_tag_ptr,
    output logic [CNT_W-1:0]  ch_count
);
    localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SH;

    typedef struct packed {
        seq_state_e       state;
        logic [AW-1:0]    mem;
        logic [AW-1:0]    scr;
        logic [AW-1:0]    tptr;
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             irq_en;
        logic             fwd_en;
        logic             stall_src;
        logic             fin;
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    stall;
    } regs_t;

    regs_t r_q, r_d;

    // tag decode
    logic [AW-1:0] dec_mem, dec_tptr, dec_span;
    logic          dec_ends, dec_stall;

    dcs_tag_decode #(.AW(AW)) u_dec (
        .dir       (r_q.dir),
        .tptr      (r_q.tptr),
        .f_cnt     (tag_data[15:0]),
        .f_kind    (tag_data[30:28]),
        .f_addr    (tag_data[63:32]),
        .next_mem  (dec_mem),
        .next_tptr (dec_tptr),
        .span      (dec_span),
        .ends      (dec_ends),
        .stall_hit (dec_stall)
    );

    // move request formation
    logic          in_fwd;
    logic [AW-1:0] mov_mem_after, mov_scr_after;

    assign in_fwd = (r_q.state == ST_FWD);

    dcs_mover #(.AW(AW)) u_mov (
        .fwd       (in_fwd),
        .dir       (r_q.dir),
        .mem       (r_q.mem),
        .scr       (r_q.scr),
        .cnt       (r_q.cnt),
        .src       (mv_src),
        .dst       (mv_dst),
        .mv_cnt    (mv_count),
        .mem_after (mov_mem_after),
        .scr_after (mov_scr_after)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.mem       = cfg_mem_addr;
                    r_d.scr       = cfg_scr_addr;
                    r_d.tptr      = cfg_tag_ptr;
                    r_d.cnt       = cfg_count;
                    r_d.dir       = cfg_dir;
                    r_d.irq_en    = cfg_irq_en;
                    r_d.fwd_en    = cfg_fwd_en;
                    r_d.stall_src = cfg_stall_src;
                    if (!cfg_chain) begin
                        r_d.fin   = 1'b1;
                        r_d.state = (cfg_count != '0) ? ST_MOVE : ST_DONE;
                    end else if (cfg_count != '0) begin
                        r_d.fin   = resume_ends(cfg_dir, cfg_last_id);
                        r_d.state = ST_MOVE;
                    end else begin
                        r_d.fin   = 1'b0;
                        r_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (tag_ack) begin
                    r_d.cnt  = tag_data[15:0];
                    r_d.mem  = dec_mem;
                    r_d.tptr = dec_tptr;
                    r_d.tag  = tag_data;
                    r_d.fin  = dec_ends | (r_q.irq_en & tag_data[31]);
                    if (!r_q.dir) begin
                        r_d.scr = r_q.scr + QW_BYTES;
                        if (dec_stall && r_q.stall_src) begin
                            r_d.stall = dec_mem + dec_span;
                        end
                    end
                    if (r_q.dir && r_q.fwd_en) begin
                        r_d.state = ST_FWD;
                    end else begin
                        r_d.state = (tag_data[15:0] != '0) ? ST_MOVE : ST_CHECK;
                    end
                end
            end
            ST_FWD: begin
                if (mv_ack) begin
                    r_d.scr   = mov_scr_after;
                    r_d.state = (r_q.cnt != '0) ? ST_MOVE : ST_CHECK;
                end
            end
            ST_MOVE: begin
                if (mv_ack) begin
                    r_d.mem   = mov_mem_after;
                    r_d.scr   = mov_scr_after;
                    r_d.cnt   = '0;
                    r_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                r_d.state = r_q.fin ? ST_DONE : ST_FETCH;
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tag_req     = (r_q.state == ST_FETCH);
    assign tag_addr    = r_q.dir ? r_q.tptr : r_q.scr;
    assign mv_req      = (r_q.state == ST_MOVE) || in_fwd;
    assign mv_fwd      = in_fwd;
    assign mv_tag      = r_q.tag;
    assign busy        = (r_q.state != ST_IDLE);
    assign irq         = (r_q.state == ST_DONE);
    assign stall_addr  = r_q.stall;
    assign ch_mem_addr = r_q.mem;
    assign ch_scr_addr = r_q.scr;
    assign ch_tag_ptr  = r_q.tptr;
    assign ch_count    = r_q.cnt;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(tag_req && mv_req)); // R13

    AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_ack) |=> (mv_req && $stable(mv_src) && $stable(mv_dst) && $stable(mv_count))); // R13

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_req && !tag_ack) |=> (tag_req && $stable(tag_addr))); // R13

    AST_IRQ_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy); // R11

    AST_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy); // R11

    AST_NO_EMPTY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (mv_count != '0)); // R9

    AST_STALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stall_addr) |-> ($past(tag_ack) && $past(tag_req))); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !irq && start) |=> busy); // R12

endmodule

// File: tb/test_dma_chain_seq.sv
`timescale 1ns/100ps
module test_dma_chain_seq;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_chain = 1'b0, cfg_dir = 1'b0, cfg_irq_en = 1'b0, cfg_fwd_en = 1'b0, cfg_stall_src = 1'b0;
    logic [2:0]  cfg_last_id = 3'd0;
    logic [15:0] cfg_count = '0;
    logic [31:0] cfg_mem_addr = '0, cfg_scr_addr = '0, cfg_tag_ptr = '0;
    logic        tag_req, tag_ack = 1'b0;
    logic [31:0] tag_addr;
    logic [127:0] tag_data = '0;
    logic        mv_req, mv_fwd, mv_ack = 1'b0;
    logic [31:0] mv_src, mv_dst;
    logic [15:0] mv_count;
    logic [127:0] mv_tag;
    logic        busy, irq;
    logic [31:0] stall_addr, ch_mem_addr, ch_scr_addr, ch_tag_ptr;
    logic [15:0] ch_count;

    dma_chain_seq #(.AW(AW)) i_dma_chain_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_chain(cfg_chain), .cfg_dir(cfg_dir), .cfg_irq_en(cfg_irq_en),
        .cfg_fwd_en(cfg_fwd_en), .cfg_stall_src(cfg_stall_src), .cfg_last_id(cfg_last_id),
        .cfg_count(cfg_count), .cfg_mem_addr(cfg_mem_addr), .cfg_scr_addr(cfg_scr_addr),
        .cfg_tag_ptr(cfg_tag_ptr),
        .tag_req(tag_req), .tag_addr(tag_addr), .tag_ack(tag_ack), .tag_data(tag_data),
        .mv_req(mv_req), .mv_fwd(mv_fwd), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_count(mv_count), .mv_tag(mv_tag), .mv_ack(mv_ack),
        .busy(busy), .irq(irq), .stall_addr(stall_addr),
        .ch_mem_addr(ch_mem_addr), .ch_scr_addr(ch_scr_addr), .ch_tag_ptr(ch_tag_ptr),
        .ch_count(ch_count)
    );

    initial forever #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [127:0] tag_mem [0:255];
    logic [31:0]  mv_log_src [0:31];
    logic [31:0]  mv_log_dst [0:31];
    logic [15:0]  mv_log_cnt [0:31];
    logic         mv_log_fwd [0:31];
    logic [63:0]  mv_log_tag [0:31];
    logic [31:0]  tf_log [0:31];
    int mv_n = 0, tf_n = 0, irq_n = 0, proto_err = 0;
    int ack_delay = 0;

    function automatic logic [127:0] mk_tag(input logic [2:0] kind, input logic irqb,
                                            input logic [15:0] cnt, input logic [31:0] addr);
        return {64'h0, addr, irqb, kind, 12'h0, cnt};
    endfunction

    // responders and protocol monitor
    initial begin
        int tw = 0, mw = 0;
        logic [31:0] t_hold = '0, m_hold = '0;
        logic irq_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (irq_prev && busy) proto_err++;
                if (irq) irq_n++;
                irq_prev = irq;
                if (tag_req && mv_req) proto_err++;
                if (tag_ack) tag_ack = 1'b0;
                else if (tag_req) begin
                    if (tw > 0 && tag_addr !== t_hold) proto_err++;
                    t_hold = tag_addr;
                    if (tw < ack_delay) tw++;
                    else begin
                        tw = 0;
                        tag_ack = 1'b1;
                        tag_data = tag_mem[tag_addr[11:4]];
                        if (tf_n < 32) tf_log[tf_n] = tag_addr;
                        tf_n++;
                    end
                end
                if (mv_ack) mv_ack = 1'b0;
                else if (mv_req) begin
                    if (mw > 0 && mv_dst !== m_hold) proto_err++;
                    m_hold = mv_dst;
                    if (mw < ack_delay) mw++;
                    else begin
                        mw = 0;
                        mv_ack = 1'b1;
                        if (mv_n < 32) begin
                            mv_log_src[mv_n] = mv_src;
                            mv_log_dst[mv_n] = mv_dst;
                            mv_log_cnt[mv_n] = mv_count;
                            mv_log_fwd[mv_n] = mv_fwd;
                            mv_log_tag[mv_n] = mv_tag[63:0];
                        end
                        mv_n++;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int i = 0; i < 256; i++) tag_mem[i] = '0;
        mv_n = 0; tf_n = 0; irq_n = 0; proto_err = 0;
    endtask

    task automatic set_cfg(input logic chain, input logic dir, input logic ien, input logic fen,
                           input logic ssrc, input logic [2:0] last, input logic [15:0] cnt,
                           input logic [31:0] mem, input logic [31:0] scr, input logic [31:0] tp);
        cfg_chain = chain; cfg_dir = dir; cfg_irq_en = ien; cfg_fwd_en = fen;
        cfg_stall_src = ssrc; cfg_last_id = last; cfg_count = cnt;
        cfg_mem_addr = mem; cfg_scr_addr = scr; cfg_tag_ptr = tp;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (busy) begin
            n_tests++;
            n_fail++;
            $display("FAIL %s: actual busy expected idle (timeout)", req);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_move(input string req, input int idx, input logic fwd,
                            input logic [31:0] src, input logic [31:0] dst, input logic [15:0] cnt);
        check({req, " move fwd"}, 64'(mv_log_fwd[idx]), 64'(fwd));
        if (!fwd) check({req, " move src"}, 64'(mv_log_src[idx]), 64'(src));
        check({req, " move dst"}, 64'(mv_log_dst[idx]), 64'(dst));
        check({req, " move cnt"}, 64'(mv_log_cnt[idx]), 64'(cnt));
    endtask

    // R1
    task automatic t_reset();
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 tag_req", 64'(tag_req), 64'd0);
        check("R1 mv_req", 64'(mv_req), 64'd0);
        check("R1 stall_addr", 64'(stall_addr), 64'd0);
    endtask

    // R2, R11, R12
    task automatic t_normal();
        clear_logs();
        set_cfg(0, 0, 0, 0, 0, 3'd0, 16'd3, 32'h1000, 32'h2000, 32'h0);
        pulse_start();
        wait_idle("R2");
        check("R2 move count", 64'(mv_n), 64'd1);
        chk_move("R2 dir0", 0, 0, 32'h2000, 32'h1000, 16'd3);
        check("R2 mem after", 64'(ch_mem_addr), 64'h1030);
        check("R2 scr after", 64'(ch_scr_addr), 64'h2030);
        check("R11 irq pulses", 64'(irq_n), 64'd1);
        check("R11 irq then idle", 64'(proto_err), 64'd0);

        clear_logs();
        set_cfg(0, 1, 0, 0, 0, 3'd0, 16'd1, 32'h4000, 32'h0050, 32'h0);
        pulse_start();
        wait_idle("R2");
        check("R2 dir1 moves", 64'(mv_n), 64'd1);
        chk_move("R2 dir1", 0, 0, 32'h4000, 32'h0050, 16'd1);

        clear_logs();
        set_cfg(0, 0, 0, 0, 0, 3'd0, 16'd0, 32'h4000, 32'h0050, 32'h0);
        pulse_start();
        wait_idle("R2");
        check("R2 zero count moves", 64'(mv_n), 64'd0);
        check("R2 zero count irq", 64'(irq_n), 64'd1);

        // R12: second start while busy
        clear_logs();
        set_cfg(0, 0, 0, 0, 0, 3'd0, 16'd2, 32'h1000, 32'h2000, 32'h0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        set_cfg(1, 1, 0, 0, 0, 3'd7, 16'd5, 32'h9000, 32'h9000, 32'h9000);
        @(negedge clk);
        start = 1'b0;
        wait_idle("R12");
        check("R12 moves", 64'(mv_n), 64'd1);
        chk_move("R12", 0, 0, 32'h2000, 32'h1000, 16'd2);
        check("R12 irq", 64'(irq_n), 64'd1);
    endtask

    // R3, R4, R9, R5 (no change)
    task automatic t_dest_chain();
        clear_logs();
        tag_mem[8'h00] = mk_tag(3'd1, 0, 16'd2, 32'h5000);
        tag_mem[8'h03] = mk_tag(3'd5, 0, 16'd0, 32'h6000);
        tag_mem[8'h04] = mk_tag(3'd7, 0, 16'd1, 32'h7000);
        set_cfg(1, 0, 0, 0, 1, 3'd0, 16'd0, 32'h0, 32'h0, 32'h0);
        pulse_start();
        wait_idle("R3");
        check("R3 fetches", 64'(tf_n), 64'd3);
        check("R3 fetch0", 64'(tf_log[0]), 64'h000);
        check("R3 fetch1", 64'(tf_log[1]), 64'h030);
        check("R4 other kind continues", 64'(tf_log[2]), 64'h040);
        check("R9 zero count tag no move", 64'(mv_n), 64'd2);
        chk_move("R3", 0, 0, 32'h010, 32'h5000, 16'd2);
        chk_move("R4", 1, 0, 32'h050, 32'h7000, 16'd1);
        check("R3 scr final", 64'(ch_scr_addr), 64'h060);
        check("R3 mem final", 64'(ch_mem_addr), 64'h7010);
        check("R5 stall unchanged", 64'(stall_addr), 64'h0);
        check("R11 irq", 64'(irq_n), 64'd1);
    endtask

    // R5 and R6 in one tag
    task automatic t_stall_irq();
        clear_logs();
        tag_mem[8'h10] = mk_tag(3'd0, 1, 16'd4, 32'h8000);
        tag_mem[8'h15] = mk_tag(3'd7, 0, 16'd1, 32'hB000);
        set_cfg(1, 0, 1, 0, 1, 3'd0, 16'd0, 32'h0, 32'h100, 32'h0);
        pulse_start();
        wait_idle("R6");
        check("R5 stall addr", 64'(stall_addr), 64'h8040);
        check("R6 one fetch", 64'(tf_n), 64'd1);
        check("R6 one move", 64'(mv_n), 64'd1);
        chk_move("R6", 0, 0, 32'h110, 32'h8000, 16'd4);
        check("R6 irq", 64'(irq_n), 64'd1);
    endtask

    // R7, R8, R6 (disabled), R13
    task automatic t_src_chain();
        clear_logs();
        ack_delay = 2;
        tag_mem[8'h40] = mk_tag(3'd1, 0, 16'd2, 32'h0);
        tag_mem[8'h43] = mk_tag(3'd2, 0, 16'd1, 32'h600);
        tag_mem[8'h60] = mk_tag(3'd3, 1, 16'd1, 32'h900);
        tag_mem[8'h61] = mk_tag(3'd0, 0, 16'd0, 32'hA00);
        set_cfg(1, 1, 0, 1, 0, 3'd0, 16'd0, 32'h0, 32'h0, 32'h400);
        pulse_start();
        wait_idle("R7");
        ack_delay = 0;
        check("R7 fetches", 64'(tf_n), 64'd4);
        check("R7 fetch1", 64'(tf_log[1]), 64'h430);
        check("R7 fetch2", 64'(tf_log[2]), 64'h600);
        check("R6 disabled bit continues", 64'(tf_log[3]), 64'h610);
        check("R8 moves", 64'(mv_n), 64'd7);
        chk_move("R8", 0, 1, 32'h0, 32'h000, 16'd1);
        check("R8 tag data", mv_log_tag[0], tag_mem[8'h40][63:0]);
        chk_move("R7 cont", 1, 0, 32'h410, 32'h010, 16'd2);
        chk_move("R8", 2, 1, 32'h0, 32'h030, 16'd1);
        chk_move("R7 next", 3, 0, 32'h440, 32'h040, 16'd1);
        chk_move("R7 ref", 5, 0, 32'h900, 32'h060, 16'd1);
        chk_move("R8 last", 6, 1, 32'h0, 32'h070, 16'd1);
        check("R8 last tag", mv_log_tag[6], tag_mem[8'h61][63:0]);
        check("R7 mem final", 64'(ch_mem_addr), 64'hA00);
        check("R7 ptr final", 64'(ch_tag_ptr), 64'h620);
        check("R8 scr final", 64'(ch_scr_addr), 64'h080);
        check("R13 protocol", 64'(proto_err), 64'd0);
    endtask

    // R10
    task automatic t_resume();
        clear_logs();
        tag_mem[8'h10] = mk_tag(3'd7, 0, 16'd1, 32'hC000);
        set_cfg(1, 1, 0, 1, 0, 3'd0, 16'd2, 32'h300, 32'h100, 32'h100);
        pulse_start();
        wait_idle("R10");
        check("R10 end kind no fetch", 64'(tf_n), 64'd0);
        check("R10 one move", 64'(mv_n), 64'd1);
        chk_move("R10", 0, 0, 32'h300, 32'h100, 16'd2);

        clear_logs();
        tag_mem[8'h19] = mk_tag(3'd7, 0, 16'd0, 32'h3000);
        set_cfg(1, 0, 0, 0, 0, 3'd0, 16'd1, 32'h2000, 32'h180, 32'h0);
        pulse_start();
        wait_idle("R10");
        check("R10 pending move count", 64'(mv_n), 64'd1);
        chk_move("R10 pending", 0, 0, 32'h180, 32'h2000, 16'd1);
        check("R10 fetch after", 64'(tf_n), 64'd1);
        check("R10 fetch addr", 64'(tf_log[0]), 64'h190);
        check("R10 mem final", 64'(ch_mem_addr), 64'h3000);
        check("R10 irq", 64'(irq_n), 64'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_dest_chain();
        t_stall_irq();
        t_src_chain();
        t_resume();
        finish_run();
    end

endmodule